// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

This block is the digital control core of a bus switch that fans one upstream two-wire serial bus out to eight downstream channels. It acts as a slave on the upstream bus and holds one 8-bit selection register. Each bit of the register drives one channel-enable output. Any mix of bits may be set, so several channels can be enabled at once. The analog pass gates sit outside and follow `chan_en`.

The clock and data lines are first brought into the system clock domain by two flops per line. Each line then passes a counter filter, which removes spikes shorter than `FILT_CYCLES` clocks. The protocol engine watches the filtered lines for START and STOP conditions and takes in the address byte. When the address matches, it acknowledges. On a write it captures the data bytes; on a read it shifts the register out. A written value is held in the register but reaches the enables only when a STOP is seen. This keeps every downstream line idle-high at the moment of connection. The active-low reset clears both the register and the enables and returns the engine to idle.

Protocol states are `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_WR_DATA`, `ST_WR_ACK`, `ST_RD_DATA`, `ST_RD_ACK` and `ST_IGNORE`. A STOP moves any state to `ST_IDLE`. A START, including a repeated one, moves any state to `ST_ADDR`. Otherwise the states change on SCL edges:
- `ST_ADDR` goes to `ST_ADDR_ACK` on the SCL fall after eight bits when the address matches, and to `ST_IGNORE` when it does not.
- `ST_ADDR_ACK` goes to `ST_RD_DATA` or `ST_WR_DATA` on the next fall, depending on the direction bit.
- `ST_WR_DATA` goes to `ST_WR_ACK` after eight bits. `ST_WR_ACK` goes back to `ST_WR_DATA`.
- `ST_RD_DATA` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_DATA` when the master acknowledges, or to `ST_IGNORE` when it does not.

Top module: `i2c_chan_switch`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1110 followed by `addr_pins[2:0]`. It acknowledges by asserting `sda_oe` (pulling SDA low) through the ninth clock. Address bit 0 is the direction: 1 is read, 0 is write.
- R2: After a non-matching address the slave asserts no acknowledge and ignores all bytes until the next START or STOP. The register and the enables keep their values.
- R3: On a write, each data byte is stored in the register. When several data bytes come in one transaction, the last one is the value kept.
- R4: `chan_en` takes the register value only on a STOP. Until the STOP, the previous enables stay in force.
- R5: On a read, the slave returns the register MSB first; this is the last written value, even before a STOP. After the master's not-acknowledge, the slave releases SDA so that the master can issue a STOP.
- R6: The slave acknowledges every data byte it receives on a write.
- R7: `sda_oe` changes only while the filtered SCL is low.
- R8: An active-low `rst_n` clears the register and `chan_en` to 0x00 and returns the engine to idle with SDA released.
- R9: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks has no effect on the protocol.
- R10: A repeated START, with no STOP before it, restarts address reception.
- R11: Register bit n drives `chan_en[n]`, and any combination of bits may be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Upstream serial clock as seen on the bus |
| sda_in | input | 1 | Upstream serial data as seen on the bus |
| addr_pins | input | 3 | Strapped low three bits of the slave address |
| sda_oe | output | 1 | When high, pulls upstream SDA low (open drain) |
| chan_en | output | 8 | Enable for each downstream channel |

## Verification
The bench uses the default `FILT_CYCLES` of 13, which is 52 ns at the 4 ns clock. It drives SCL with a half period of 50 clocks, so one bit is long enough to clear both the synchronizer and the filter. With these values, a 5-clock spike on SCL inside a data bit is short enough to be removed by the filter. The same spike would add a ninth bit and corrupt the stored byte if the filter let it through. The address pins are strapped to 101. A second address pattern with different low bits then exercises the mismatch path alongside writes, reads and repeated STARTs.

// File: rtl/chsw_pkg.sv
package chsw_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] ADDR_FIXED = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } chsw_state_t;
endpackage

// File: rtl/chsw_line_filter.sv
module chsw_line_filter #(
    parameter int   FILT_CYCLES = 13,
    parameter logic IDLE_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LIM = CW'(FILT_CYCLES - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{IDLE_VAL}};
            cnt_q  <= '0;
            dout   <= IDLE_VAL;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LIM) begin
                cnt_q <= '0;
                dout  <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_filt_follows_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(sync_q[1]) == dout));

    assert_filt_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LIM);
endmodule

// File: rtl/chsw_proto_fsm.sv
module chsw_proto_fsm
    import chsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [2:0]        addr_pins,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] chan_en
);
    chsw_state_t       state, state_nxt;
    logic              scl_q, sda_q;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ctrl_reg;
    logic              rw_q;

    wire scl_rise  = scl_f & ~scl_q;
    wire scl_fall  = ~scl_f & scl_q;
    wire start_evt = scl_f & scl_q & sda_q & ~sda_f;
    wire stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
    wire byte_done = (bitcnt == 4'd8);
    wire addr_hit  = (shreg[7:1] == {ADDR_FIXED, addr_pins});

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (stop_evt) begin
            state_nxt = ST_IDLE;
        end else if (start_evt) begin
            state_nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_done)
                                 state_nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nxt = rw_q ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && byte_done) state_nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nxt = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && byte_done) state_nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_rise && sda_f) state_nxt = ST_IGNORE;
                             else if (scl_fall) state_nxt = ST_RD_DATA;
                ST_IGNORE:   state_nxt = ST_IGNORE;
                default:     state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            bitcnt   <= '0;
            shreg    <= '0;
            ctrl_reg <= '0;
            chan_en  <= '0;
            rw_q     <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (stop_evt) begin
                chan_en <= ctrl_reg;
                sda_oe  <= 1'b0;
                bitcnt  <= '0;
            end else if (start_evt) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (scl_rise) begin
                unique case (state)
                    ST_ADDR, ST_WR_DATA: begin
                        shreg  <= {shreg[6:0], sda_f};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    ST_RD_DATA: bitcnt <= bitcnt + 1'b1;
                    default: ;
                endcase
            end else if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (byte_done && addr_hit) begin
                        sda_oe <= 1'b1;
                        rw_q   <= shreg[0];
                    end
                    ST_ADDR_ACK: begin
                        bitcnt <= '0;
                        if (rw_q) begin
                            shreg  <= ctrl_reg;
                            sda_oe <= ~ctrl_reg[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_WR_DATA: if (byte_done) begin
                        ctrl_reg <= shreg;
                        sda_oe   <= 1'b1;
                    end
                    ST_WR_ACK: begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                    end
                    ST_RD_DATA: begin
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                    ST_RD_ACK: begin
                        shreg  <= ctrl_reg;
                        sda_oe <= ~ctrl_reg[7];
                        bitcnt <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_en_only_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> $past(stop_evt));

    assert_sda_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    assert_reg_write_in_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_reg) |-> ($past(state) == ST_WR_DATA));

    assert_silent_when_ignoring_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> !sda_oe);
endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch #(
    parameter int FILT_CYCLES = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] addr_pins,
    output logic       sda_oe,
    output logic [7:0] chan_en
);
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        chsw_line_filter #(
            .FILT_CYCLES(FILT_CYCLES),
            .IDLE_VAL   (1'b1)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    chsw_proto_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .addr_pins(addr_pins),
        .sda_oe   (sda_oe),
        .chan_en  (chan_en)
    );
endmodule

// File: tb/i2c_chan_switch_tb.sv
module i2c_chan_switch_tb;
    localparam int H = 50;
    localparam logic [2:0] PINS = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] chan_en;
    wire        sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit r7_bad = 0;
    logic oe_prev = 1'b0;

    always #2 clk = ~clk;

    i2c_chan_switch u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .addr_pins(PINS), .sda_oe(sda_oe), .chan_en(chan_en)
    );

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R7 monitor: sda_oe must not move while the bench holds SCL high
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== oe_prev)) r7_bad = 1;
        oe_prev <= sda_oe;
    end

    task automatic bus_start();
        sda_m = 1; wc(H/2); scl_m = 1; wc(H); sda_m = 0; wc(H); scl_m = 0;
    endtask

    task automatic bus_stop();
        sda_m = 0; wc(H/2); scl_m = 1; wc(H); sda_m = 1; wc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            wc(H/2); sda_m = b[i]; wc(H/2); scl_m = 1; wc(H); scl_m = 0;
        end
        wc(H/2); sda_m = 1; wc(H/2); scl_m = 1; wc(H/2);
        acked = !sda_bus;
        wc(H/2); scl_m = 0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wc(H); scl_m = 1; wc(H/2); b[i] = sda_bus; wc(H/2); scl_m = 0;
        end
        wc(H/2); sda_m = !give_ack; wc(H/2); scl_m = 1; wc(H); scl_m = 0;
        wc(H/2); sda_m = 1;
    endtask

    task automatic write_tx(input logic [7:0] d);
        bit a;
        bus_start();
        send_byte({4'b1110, PINS, 1'b0}, a); check("R1 addr ack", a, 1);
        send_byte(d, a); check("R6 data ack", a, 1);
        bus_stop();
    endtask

    task automatic read_tx(input logic [7:0] exp, input string req);
        bit a; logic [7:0] r;
        bus_start();
        send_byte({4'b1110, PINS, 1'b1}, a); check("R1 read addr ack", a, 1);
        recv_byte(0, r); check(req, r, exp);
        wc(H/4); check("R5 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R8 enables at reset", chan_en, 8'h00);
        check("R8 sda released at reset", sda_oe, 0);
    endtask

    task automatic t_write_single();
        bit a;
        bus_start();
        send_byte({4'b1110, PINS, 1'b0}, a); check("R1 addr ack", a, 1);
        send_byte(8'h4C, a); check("R6 data ack", a, 1);
        check("R4 no update before stop", chan_en, 8'h00);
        bus_stop();
        check("R11 enables after stop", chan_en, 8'h4C);
    endtask

    task automatic t_multi();
        bit a;
        bus_start();
        send_byte({4'b1110, PINS, 1'b0}, a);
        send_byte(8'h01, a); send_byte(8'h80, a);
        send_byte(8'h96, a); check("R6 third byte ack", a, 1);
        check("R4 old enables held", chan_en, 8'h4C);
        bus_stop();
        check("R3 last byte kept", chan_en, 8'h96);
    endtask

    task automatic t_read();
        read_tx(8'h96, "R5 read data");
    endtask

    task automatic t_repstart();
        bit a; logic [7:0] r;
        bus_start();
        send_byte({4'b1110, PINS, 1'b0}, a);
        send_byte(8'h5A, a);
        bus_start();
        send_byte({4'b1110, PINS, 1'b1}, a); check("R10 ack after repeated start", a, 1);
        recv_byte(0, r); check("R5 pending value readable", r, 8'h5A);
        check("R4 enables unchanged pre-stop", chan_en, 8'h96);
        bus_stop();
        check("R10 applied at stop", chan_en, 8'h5A);
    endtask

    task automatic t_mismatch();
        bit a;
        bus_start();
        send_byte({4'b1110, 3'b011, 1'b0}, a); check("R2 no ack on mismatch", a, 0);
        send_byte(8'hFF, a); check("R2 no ack for ignored byte", a, 0);
        bus_stop();
        check("R2 enables unchanged", chan_en, 8'h5A);
        read_tx(8'h5A, "R2 register unchanged");
    endtask

    task automatic t_glitch();
        bit a;
        bus_start();
        send_byte({4'b1110, PINS, 1'b0}, a);
        // first data bit with a 5-clock SCL spike while low
        wc(H/4); sda_m = 1; wc(H/8); scl_m = 1; wc(5); scl_m = 0; wc(H/8);
        scl_m = 1; wc(H); scl_m = 0;
        for (int i = 6; i >= 0; i--) begin
            wc(H/2); sda_m = 8'hA5 >> i; wc(H/2); scl_m = 1; wc(H); scl_m = 0;
        end
        wc(H/2); sda_m = 1; wc(H/2); scl_m = 1; wc(H/2);
        a = !sda_bus; wc(H/2); scl_m = 0;
        check("R9 ack despite spike", a, 1);
        bus_stop();
        check("R9 spike filtered", chan_en, 8'hA5);
    endtask

    task automatic t_reset_mid();
        write_tx(8'h33);
        check("R11 enables 0x33", chan_en, 8'h33);
        rst_n = 0; wc(3); check("R8 reset clears enables", chan_en, 8'h00);
        rst_n = 1; wc(4);
        read_tx(8'h00, "R8 register cleared");
    endtask

    initial begin
        wc(5);
        t_reset();
        rst_n = 1; wc(10);
        t_write_single();
        t_multi();
        t_read();
        t_repstart();
        t_mismatch();
        t_glitch();
        t_reset_mid();
        check("R7 sda_oe stable while SCL high", r7_bad, 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule